// File: doc/BRIEF.md
# Half-Rate to Double-Data-Rate Output Path

This block sits between core logic and a single output pin. Core logic hands it data and an output enable. The block puts both out on the pin in one of four ways. The first is a straight combinational feed-through. The second is a registered single-rate output. The third is a double-data-rate output fed at the full clock rate. The fourth is a double-data-rate output fed with four-bit words on a clock of half the frequency. In that last case a conversion stage on the half-rate clock splits each word into two bit pairs, one per full-rate cycle. A rising-edge register and a falling-edge register then share each pair, and the full-rate clock selects between them.

The output enable does not have a path of its own. It travels through a second copy of the same lane as the data. In every mode, therefore, the pin and its enable change in the same cycle. The mode is captured while reset is held and stays fixed until the next reset. The full-rate clock must run at twice the half-rate clock and be phase-aligned with it. Which full-rate cycle is the first of a pair is worked out from the clocks themselves.

Top module: `hr_ddr_out`

## Requirements
- R1: While `rst` is high, `pinData` and `pinOe` are both 0 in every mode, the pass-through mode included.
- R2: `modeSel` is captured only while `rst` is high: 0 is pass-through, 1 is single-rate, 2 is full-rate DDR, 3 is half-rate DDR. Changes to `modeSel` after reset is released have no effect on the pins.
- R3: In pass-through mode, `pinData` follows `dataIn[0]` and `pinOe` follows `oeIn[0]` with no register in between.
- R4: In single-rate mode, `dataIn[0]` sampled at a rising `clkFull` edge drives `pinData` for the whole cycle that this edge starts.
- R5: In full-rate DDR mode, the pair `dataIn[1:0]` sampled at a rising `clkFull` edge goes out in the cycle that this edge starts. Bit 0 goes out while `clkFull` is high and bit 1 while it is low.
- R6: In half-rate DDR mode, a word sampled at a rising `clkHalf` edge (full-rate edge k) goes out in the two cycles after that. Bits 0 and 1 go out in the high and low phase of the cycle that starts at edge k+2. Bits 2 and 3 go out in the high and low phase of the cycle that starts at edge k+3.
- R7: In half-rate DDR mode, `oeIn[0]` of a word drives `pinOe` through both phases of the first of its two output cycles, and `oeIn[1]` drives it through both phases of the second.
- R8: In single-rate and full-rate DDR modes, `oeIn[0]` sampled at an edge drives `pinOe` through both phases of the same cycle that carries the data sampled at that edge.
- R9: The half-rate output pairs come out in the order given in R6 whether reset is released while `clkHalf` is high or while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFull | input | 1 | Full-rate clock, twice the half-rate frequency |
| clkHalf | input | 1 | Half-rate clock, rising together with `clkFull` |
| rst | input | 1 | Asynchronous active-high reset; the mode is captured while it is high |
| modeSel | input | 2 | Output mode code (see R2) |
| dataIn | input | 4 | Core data: one word in half-rate mode, the low bits otherwise |
| oeIn | input | 2 | Core enable: two bits in half-rate mode, bit 0 otherwise |
| pinData | output | 1 | Data towards the pad |
| pinOe | output | 1 | Output enable towards the pad |

## Verification
The hardest state to reach from the ports is the half-rate pairing right after reset. The first full-rate edge after release can fall on either phase of `clkHalf`, and the serializer must still send the low pair of each word first. The bench therefore releases reset once after an edge where `clkHalf` rises and once after an edge where it falls, and checks the pair order that follows each release. While modes run it also drives random codes onto `modeSel`, to show that a running mode cannot be changed.

// File: rtl/hr_ddr_pkg.sv
package hr_ddr_pkg;

  // bits leaving the pin per full-rate cycle, and per half-rate word
  localparam int PAIR_W  = 2;
  localparam int WORD_W  = 2 * PAIR_W;
  // lane 0 carries data, lane 1 carries the output enable
  localparam int LANES   = 2;

  typedef enum logic [1:0] {
    MODE_COMB = 2'b00,
    MODE_SDR  = 2'b01,
    MODE_FDDR = 2'b10,
    MODE_HDDR = 2'b11
  } outMode_e;

  // strobes from the control to every lane
  typedef struct packed {
    logic useConv;    // take the pair from the half-rate converter
    logic bypassReg;  // pin follows the core input directly
    logic dupBit;     // single-rate: same bit in both phases
    logic firstHalf;  // this full-rate cycle carries the low pair
  } laneCtl_t;

endpackage

// File: rtl/hr_ddr_ctl.sv
module hr_ddr_ctl
  import hr_ddr_pkg::*;
(
  input  logic     clkFull,
  input  logic     clkHalf,
  input  logic     rst,
  input  logic [1:0] modeSel,
  output outMode_e modeNow,
  output laneCtl_t ctl
);

  outMode_e modeQ;
  logic     hrTog;
  logic     hrTogSeen;

  // mode is loaded only while reset is held, then frozen
  always_ff @(posedge clkFull) begin
    if (rst) modeQ <= outMode_e'(modeSel);
  end

  // toggles once per half-rate cycle
  always_ff @(posedge clkHalf or posedge rst) begin
    if (rst) hrTog <= 1'b0;
    else     hrTog <= ~hrTog;
  end

  // full-rate copy: a mismatch marks the first cycle after a new word
  always_ff @(posedge clkFull or posedge rst) begin
    if (rst) hrTogSeen <= 1'b0;
    else     hrTogSeen <= hrTog;
  end

  always_comb begin
    ctl.useConv   = (modeQ == MODE_HDDR);
    ctl.bypassReg = (modeQ == MODE_COMB);
    ctl.dupBit    = (modeQ == MODE_SDR);
    ctl.firstHalf = (hrTog != hrTogSeen);
  end

  assign modeNow = modeQ;

endmodule

// File: rtl/hr_ddr_lane.sv
module hr_ddr_lane
  import hr_ddr_pkg::*;
(
  input  logic              clkFull,
  input  logic              clkHalf,
  input  logic              rst,
  input  laneCtl_t          ctl,
  input  logic [WORD_W-1:0] wordIn,
  output logic              pinOut
);

  logic [WORD_W-1:0] hrWord;
  logic [PAIR_W-1:0] convPair;
  logic [PAIR_W-1:0] ddrIn;
  logic              riseReg;
  logic              holdLow;
  logic              fallReg;
  logic              regOut;

  // half-rate capture of the core word
  always_ff @(posedge clkHalf or posedge rst) begin
    if (rst) hrWord <= '0;
    else     hrWord <= wordIn;
  end

  // half-rate to full-rate conversion: low pair first, then high pair
  always_ff @(posedge clkFull or posedge rst) begin
    if (rst)                convPair <= '0;
    else if (ctl.firstHalf) convPair <= hrWord[PAIR_W-1:0];
    else                    convPair <= hrWord[WORD_W-1:PAIR_W];
  end

  // pick what feeds the double-rate register
  always_comb begin
    if (ctl.useConv)     ddrIn = convPair;
    else if (ctl.dupBit) ddrIn = {PAIR_W{wordIn[0]}};
    else                 ddrIn = wordIn[PAIR_W-1:0];
  end

  // double-rate register: both bits launched from the rising edge
  always_ff @(posedge clkFull or posedge rst) begin
    if (rst) begin
      riseReg <= 1'b0;
      holdLow <= 1'b0;
    end else begin
      riseReg <= ddrIn[0];
      holdLow <= ddrIn[1];
    end
  end

  // falling-edge register keeps the second bit for the low phase
  always_ff @(negedge clkFull or posedge rst) begin
    if (rst) fallReg <= 1'b0;
    else     fallReg <= holdLow;
  end

  assign regOut = clkFull ? riseReg : fallReg;

  always_comb begin
    if (rst)                pinOut = 1'b0;
    else if (ctl.bypassReg) pinOut = wordIn[0];
    else                    pinOut = regOut;
  end

endmodule

// File: rtl/hr_ddr_datapath.sv
module hr_ddr_datapath
  import hr_ddr_pkg::*;
(
  input  logic                         clkFull,
  input  logic                         clkHalf,
  input  logic                         rst,
  input  laneCtl_t                     ctl,
  input  logic [LANES-1:0][WORD_W-1:0] laneWord,
  output logic [LANES-1:0]             lanePin
);

  // identical lanes keep data and enable delays equal
  for (genvar li = 0; li < LANES; li++) begin : g_lane
    hr_ddr_lane u_lane (
      .clkFull (clkFull),
      .clkHalf (clkHalf),
      .rst     (rst),
      .ctl     (ctl),
      .wordIn  (laneWord[li]),
      .pinOut  (lanePin[li])
    );
  end

endmodule

// File: rtl/hr_ddr_out.sv
module hr_ddr_out
  import hr_ddr_pkg::*;
(
  input  logic       clkFull,
  input  logic       clkHalf,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic [3:0] dataIn,
  input  logic [1:0] oeIn,
  output logic       pinData,
  output logic       pinOe
);

  laneCtl_t                     ctl;
  outMode_e                     activeMode;
  logic [LANES-1:0][WORD_W-1:0] laneWord;
  logic [LANES-1:0]             lanePin;

  hr_ddr_ctl u_ctl (
    .clkFull (clkFull),
    .clkHalf (clkHalf),
    .rst     (rst),
    .modeSel (modeSel),
    .modeNow (activeMode),
    .ctl     (ctl)
  );

  // each enable bit is widened to a pair so it rides the data structure
  assign laneWord[0] = dataIn;
  assign laneWord[1] = {{PAIR_W{oeIn[1]}}, {PAIR_W{oeIn[0]}}};

  hr_ddr_datapath u_dp (
    .clkFull  (clkFull),
    .clkHalf  (clkHalf),
    .rst      (rst),
    .ctl      (ctl),
    .laneWord (laneWord),
    .lanePin  (lanePin)
  );

  assign pinData = lanePin[0];
  assign pinOe   = lanePin[1];

endmodule

// File: rtl/hr_ddr_out_chk.sv
module hr_ddr_out_chk
  import hr_ddr_pkg::*;
(
  input logic       clkFull,
  input logic       rst,
  input outMode_e   curMode,
  input logic [3:0] dataIn,
  input logic [1:0] oeIn,
  input logic       pinData,
  input logic       pinOe
);

  // R1: pins quiet while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clkFull)
    rst |-> (!pinData && !pinOe));

  // R2: the captured mode never moves once reset is gone
  p_mode_frozen_r2: assert property (@(posedge clkFull) disable iff (rst)
    !$past(rst) |-> $stable(curMode));

  // R3: pass-through follows the core inputs
  p_comb_follow_r3: assert property (@(posedge clkFull) disable iff (rst)
    (curMode == MODE_COMB) |-> (pinData == dataIn[0] && pinOe == oeIn[0]));

  // R4: single-rate pin carries the bit sampled one edge earlier
  p_sdr_hold_r4: assert property (@(posedge clkFull) disable iff (rst)
    (curMode == MODE_SDR && !$past(rst)) |-> (pinData == $past(dataIn[0])));

  // R8: enable keeps the data latency in the full-rate registered modes
  p_oe_latency_r8: assert property (@(posedge clkFull) disable iff (rst)
    ((curMode == MODE_SDR || curMode == MODE_FDDR) && !$past(rst))
      |-> (pinOe == $past(oeIn[0])));

endmodule

bind hr_ddr_out hr_ddr_out_chk u_chk (
  .clkFull (clkFull),
  .rst     (rst),
  .curMode (activeMode),
  .dataIn  (dataIn),
  .oeIn    (oeIn),
  .pinData (pinData),
  .pinOe   (pinOe)
);

// File: tb/hr_ddr_out_tb.sv
module hr_ddr_out_tb;
  import hr_ddr_pkg::*;

  logic       clkFull = 1'b0;
  logic       clkHalf = 1'b0;
  logic       rst     = 1'b1;
  logic [1:0] modeSel = 2'd1;
  logic [3:0] dataIn  = 4'h0;
  logic [1:0] oeIn    = 2'b00;
  logic       pinData;
  logic       pinOe;

  int vectors     = 0;
  int miscompares = 0;
  int g           = 0;
  int chkFrom     = 1 << 30;
  int dirIdx      = 0;
  bit randMode    = 1'b0;
  bit done        = 1'b0;
  outMode_e curMode = MODE_SDR;

  logic [3:0] dHist [0:2047];
  logic [1:0] oHist [0:2047];

  hr_ddr_out u_dut (
    .clkFull (clkFull),
    .clkHalf (clkHalf),
    .rst     (rst),
    .modeSel (modeSel),
    .dataIn  (dataIn),
    .oeIn    (oeIn),
    .pinData (pinData),
    .pinOe   (pinOe)
  );

  // 50 MHz full-rate clock; half-rate clock rises on odd-numbered edges
  initial forever begin
    #10 clkFull = 1'b1; clkHalf = ~clkHalf;
    #10 clkFull = 0;
  end

  always @(posedge clkFull) g = g + 1;

  function automatic logic [3:0] dirWord(int i);
    case (i)
      0: return 4'hF;  1: return 4'h0;  2: return 4'h5;  3: return 4'hA;
      4: return 4'h3;  5: return 4'hC;  6: return 4'h9;  default: return 4'h6;
    endcase
  endfunction

  // stimulus for the next edge, 2 ns after each rising edge
  always @(posedge clkFull) begin
    #2;
    if (dirIdx < 8) begin
      dataIn = dirWord(dirIdx);
      oeIn   = 2'(dirIdx + 1);
      dirIdx = dirIdx + 1;
    end else begin
      dataIn = 4'($urandom % 16);
      oeIn   = 2'($urandom % 4);
    end
    if (randMode && !rst) modeSel = 2'($urandom % 4);
    dHist[(g + 1) % 2048] = dataIn;
    oHist[(g + 1) % 2048] = oeIn;
  end

  task automatic cmp(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", tag, g, act, exp);
    end
  endtask

  // expected pin values for cycle g, phase given by lowPh
  task automatic checkPhase(bit lowPh);
    logic [3:0] w;
    logic [1:0] o;
    case (curMode)
      MODE_COMB: begin
        cmp("R3 data", pinData, dataIn[0]);
        cmp("R3 oe", pinOe, oeIn[0]);
      end
      MODE_SDR: begin
        cmp("R4 data", pinData, dHist[g % 2048][0]);
        cmp("R8 oe sdr", pinOe, oHist[g % 2048][0]);
      end
      MODE_FDDR: begin
        w = dHist[g % 2048];
        cmp("R5 data", pinData, lowPh ? w[1] : w[0]);
        cmp("R8 oe ddr", pinOe, oHist[g % 2048][0]);
      end
      default: begin
        if (g % 2 == 1) begin
          w = dHist[(g - 2) % 2048];
          o = oHist[(g - 2) % 2048];
          cmp("R6 R9 low pair", pinData, lowPh ? w[1] : w[0]);
          cmp("R7 oe first", pinOe, o[0]);
        end else begin
          w = dHist[(g - 3) % 2048];
          o = oHist[(g - 3) % 2048];
          cmp("R6 R9 high pair", pinData, lowPh ? w[3] : w[2]);
          cmp("R7 oe second", pinOe, o[1]);
        end
      end
    endcase
  endtask

  task automatic doReset(outMode_e m, int parity);
    randMode = 1'b0;
    @(posedge clkFull);
    #1 rst = 1'b1; modeSel = m; curMode = m;
    for (int i = 0; i < 4; i++) begin
      @(posedge clkFull);
      #5  cmp("R1 data", pinData, 1'b0); cmp("R1 oe", pinOe, 1'b0);
      #10 cmp("R1 data", pinData, 1'b0); cmp("R1 oe", pinOe, 1'b0);
    end
    @(posedge clkFull);
    while (g % 2 != parity) @(posedge clkFull);
    #1 rst = 1'b0;
    dirIdx  = 0;
    chkFrom = g + 4;
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clkFull);
      #5  if (g >= chkFrom) checkPhase(1'b0);
      #10 if (g >= chkFrom) checkPhase(1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset(MODE_SDR, 1);  runCycles(60);
    doReset(MODE_COMB, 0); runCycles(40);
    doReset(MODE_FDDR, 1); runCycles(80);
    // R9: release after a half-clock rising edge, then after a falling one
    doReset(MODE_HDDR, 1); runCycles(80);
    doReset(MODE_HDDR, 0); randMode = 1'b1; runCycles(80);
    // R2: mode code scrambled while running must not matter
    doReset(MODE_FDDR, 0); randMode = 1'b1; runCycles(60);
    doReset(MODE_SDR, 0);  randMode = 1'b1; runCycles(40);
    doReset(MODE_COMB, 1); randMode = 1'b1; runCycles(30);
    randMode = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule